// File: doc/BRIEF.md
# Audio Codec Power Sequencing Controller

This block decides when the sub-blocks of an audio codec may run. It takes three power-management request bits (charge pump, ADC, DAC), a 4-bit sample-rate code, the active-low reset pin, and the raw master and frame clocks of the audio path. From these it produces a charge-pump enable, a charge-pump ready flag, an unsupported-rate error flag, and run enables for the ADC and the DAC. All logic runs on a fast system clock. The two audio clocks are treated as slow data: each goes through a two-flop synchronizer and a rising-edge detector.

A watchdog counter per audio clock declares that clock present while its rising edges keep arriving within a programmable number of system cycles. The charge-pump ready flag rises after a settle interval. That interval is measured in frame-clock rising edges, its length depends on the rate code, and it advances only while both clocks are present. The ADC run enable waits for a frame-clock edge with both clocks present. The DAC run enable needs only both clocks present. Clearing a request bit drops the matching outputs at the next system clock edge.

Top module: `pwrseq_ctrl`

## Requirements
- R1: While rst_n is low, cp_en, cp_ready, rate_err, adc_run and dac_run are all 0, whatever the request bits and clocks are doing.
- R2: After rst_n is released, every output stays 0 while all request bits are 0, even with both audio clocks running.
- R3: cp_en follows pm_cp with one system clock of delay.
- R4: With pm_cp at 1 and a supported rate code, cp_ready rises on the settle-th frame-clock rising edge counted after pm_cp was set, and not before. The settle counts by rate code are: 4'b0000 and 4'b0010: 512; 4'b0001, 4'b1000 and 4'b1010: 256; 4'b1001, 4'b1100 and 4'b1110: 128; 4'b1101: 64.
- R5: For any other rate code with pm_cp at 1, rate_err is 1 and cp_ready never rises. For a supported code, rate_err is 0.
- R6: Frame-clock edges arriving while either audio clock is absent do not advance the settle count. Counting resumes from where it stopped once both clocks are present again.
- R7: After pm_adc is set, adc_run rises only on a frame-clock rising edge that arrives while both clocks are present. It stays 0 without such an edge, and also while the master clock is absent.
- R8: With pm_dac at 1, dac_run is 1 whenever both clocks are present, without waiting for a new frame-clock edge.
- R9: An audio clock is declared absent when no rising edge of it is seen for TIMEOUT system cycles. This drops adc_run and dac_run.
- R10: Clearing a request bit drops its outputs at the next system clock edge and discards progress. Setting pm_cp again requires the full settle count.
- R11: A rate-code change while pm_cp is 1 restarts the settle count from zero, using the settle value of the new code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset pin, asynchronous |
| pm_cp | input | 1 | Charge-pump power request |
| pm_adc | input | 1 | ADC power request |
| pm_dac | input | 1 | DAC power request |
| rate_code | input | 4 | Sample-rate code |
| mclk_in | input | 1 | Raw master clock |
| fclk_in | input | 1 | Raw frame clock |
| cp_en | output | 1 | Charge-pump enable |
| cp_ready | output | 1 | Charge-pump settle interval complete |
| rate_err | output | 1 | Unsupported rate code with charge pump requested |
| adc_run | output | 1 | ADC run enable |
| dac_run | output | 1 | DAC run enable |

## Verification
The bench sweeps all sixteen rate codes. It stops one frame edge short of each settle count and then gives the last edge, so an off-by-one or a wrong table entry shows up as ready asserting early or late. Invalid codes are given more edges than the longest count, which catches a design that falls back to a default interval. The bench stops the master clock in the middle of a count and also changes the rate code in the middle of a count. A design that keeps counting without a clock, or that continues from the old count, would then raise ready too early. The ADC and DAC tests separate waiting for an edge from waiting only for presence: swapping the two behaviours makes one of the enables rise at the wrong time.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    localparam int CNT_W = 10;

    typedef struct packed {
        logic             valid;
        logic [CNT_W-1:0] settle;
    } rate_cfg_t;

    function automatic rate_cfg_t rate_cfg(input logic [3:0] code);
        rate_cfg_t c;
        c.valid = 1'b1;
        unique case (code)
            4'b0000, 4'b0010:          c.settle = CNT_W'(512);
            4'b0001, 4'b1000, 4'b1010: c.settle = CNT_W'(256);
            4'b1001, 4'b1100, 4'b1110: c.settle = CNT_W'(128);
            4'b1101:                   c.settle = CNT_W'(64);
            default: begin
                c.valid  = 1'b0;
                c.settle = '0;
            end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pwrseq_edge_sync.sv
module pwrseq_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    typedef struct packed {
        logic [2:0] sh;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.sh = {s_q.sh[1:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // sh[1] is the second synchronizer stage, sh[2] its delayed copy
    assign rise = s_q.sh[1] & ~s_q.sh[2];
endmodule

// File: rtl/pwrseq_clk_watch.sv
module pwrseq_clk_watch #(
    parameter int TIMEOUT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_seen,
    output logic present
);
    localparam int TO_W = $clog2(TIMEOUT + 1);

    typedef struct packed {
        logic            alive;
        logic [TO_W-1:0] cnt;
    } watch_t;

    watch_t w_d, w_q;

    always_comb begin
        w_d = w_q;
        if (edge_seen) begin
            w_d.alive = 1'b1;
            w_d.cnt   = '0;
        end else if (w_q.alive) begin
            if (w_q.cnt == TO_W'(TIMEOUT - 1)) begin
                w_d.alive = 1'b0;
                w_d.cnt   = '0;
            end else begin
                w_d.cnt = w_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    // an edge in this cycle already counts as evidence of a running clock
    assign present = w_q.alive | edge_seen;
endmodule

// File: rtl/pwrseq_cp_timer.sv
module pwrseq_cp_timer
    import pwrseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pm_cp,
    input  logic [3:0] rate_code,
    input  logic       clocks_ok,
    input  logic       f_rise,
    output logic       cp_en,
    output logic       cp_ready,
    output logic       rate_err
);
    typedef struct packed {
        logic             en;
        logic             ready;
        logic             err;
        logic [3:0]       rate;
        logic [CNT_W-1:0] cnt;
    } cp_t;

    cp_t c_d, c_q;
    rate_cfg_t cfg;

    always_comb begin
        cfg    = rate_cfg(rate_code);
        c_d    = c_q;
        c_d.en = pm_cp;
        c_d.err = pm_cp & ~cfg.valid;
        if (!pm_cp || rate_code != c_q.rate) begin
            c_d.cnt   = '0;
            c_d.ready = 1'b0;
            c_d.rate  = rate_code;
        end else if (cfg.valid && !c_q.ready && clocks_ok && f_rise) begin
            c_d.cnt = c_q.cnt + 1'b1;
            if (c_d.cnt == cfg.settle) c_d.ready = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cp_en    = c_q.en;
    assign cp_ready = c_q.ready;
    assign rate_err = c_q.err;
endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl #(
    parameter int TIMEOUT = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pm_cp,
    input  logic       pm_adc,
    input  logic       pm_dac,
    input  logic [3:0] rate_code,
    input  logic       mclk_in,
    input  logic       fclk_in,
    output logic       cp_en,
    output logic       cp_ready,
    output logic       rate_err,
    output logic       adc_run,
    output logic       dac_run
);
    localparam int N_CLK = 2;

    logic [N_CLK-1:0] ext_clk;
    logic [N_CLK-1:0] rise;
    logic [N_CLK-1:0] present;
    logic             f_rise;
    logic             clocks_ok;

    // index 0: frame clock, index 1: master clock
    assign ext_clk = {mclk_in, fclk_in};

    for (genvar i = 0; i < N_CLK; i++) begin : g_clk
        pwrseq_edge_sync u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (ext_clk[i]),
            .rise     (rise[i])
        );
        pwrseq_clk_watch #(.TIMEOUT(TIMEOUT)) u_watch (
            .clk       (clk),
            .rst_n     (rst_n),
            .edge_seen (rise[i]),
            .present   (present[i])
        );
    end

    assign f_rise    = rise[0];
    assign clocks_ok = &present;

    pwrseq_cp_timer u_cp (
        .clk       (clk),
        .rst_n     (rst_n),
        .pm_cp     (pm_cp),
        .rate_code (rate_code),
        .clocks_ok (clocks_ok),
        .f_rise    (f_rise),
        .cp_en     (cp_en),
        .cp_ready  (cp_ready),
        .rate_err  (rate_err)
    );

    typedef struct packed {
        logic adc;
        logic dac;
    } run_t;

    run_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.adc = pm_adc & clocks_ok & (r_q.adc | f_rise);
        r_d.dac = pm_dac & clocks_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign adc_run = r_q.adc;
    assign dac_run = r_q.dac;
endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk (
    input logic clk,
    input logic rst_n,
    input logic pm_cp,
    input logic pm_adc,
    input logic pm_dac,
    input logic f_rise,
    input logic clocks_ok,
    input logic cp_en,
    input logic cp_ready,
    input logic rate_err,
    input logic adc_run,
    input logic dac_run
);
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_quiet: assert (!cp_en && !cp_ready && !rate_err && !adc_run && !dac_run)
                else $error("R1 output active in reset");
        end
    end

    a_r4_ready_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        cp_ready |-> cp_en);

    a_r4_ready_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cp_ready) |-> $past(f_rise));

    a_r5_err_blocks_ready: assert property (@(posedge clk) disable iff (!rst_n)
        rate_err |-> !cp_ready);

    a_r7_adc_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_run) |-> $past(f_rise && clocks_ok));

    a_r8_dac_needs_clocks: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_run) |-> $past(clocks_ok));

    a_r10_cp_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !pm_cp |=> (!cp_en && !cp_ready));

    a_r10_adc_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !pm_adc |=> !adc_run);

    a_r10_dac_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !pm_dac |=> !dac_run);
endmodule

bind pwrseq_ctrl pwrseq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pm_cp     (pm_cp),
    .pm_adc    (pm_adc),
    .pm_dac    (pm_dac),
    .f_rise    (f_rise),
    .clocks_ok (clocks_ok),
    .cp_en     (cp_en),
    .cp_ready  (cp_ready),
    .rate_err  (rate_err),
    .adc_run   (adc_run),
    .dac_run   (dac_run)
);

// File: tb/sim_pwrseq_ctrl.sv
`timescale 1ns/1ps
module sim_pwrseq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pm_cp = 1'b0, pm_adc = 1'b0, pm_dac = 1'b0;
    logic [3:0] rate_code = 4'b0000;
    logic       mclk_in = 1'b0, fclk_in = 1'b0;
    logic       mclk_on = 1'b1;
    logic       cp_en, cp_ready, rate_err, adc_run, dac_run;
    int         tests = 0, fails = 0;

    pwrseq_ctrl #(.TIMEOUT(32)) u0 (
        .clk(clk), .rst_n(rst_n), .pm_cp(pm_cp), .pm_adc(pm_adc), .pm_dac(pm_dac),
        .rate_code(rate_code), .mclk_in(mclk_in), .fclk_in(fclk_in),
        .cp_en(cp_en), .cp_ready(cp_ready), .rate_err(rate_err),
        .adc_run(adc_run), .dac_run(dac_run)
    );

    always #5 clk = ~clk;
    always begin
        #20;
        if (mclk_on) mclk_in = ~mclk_in;
    end

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic fclk_edge();
        @(negedge clk) fclk_in = 1'b1;
        repeat (4) @(negedge clk);
        fclk_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic fclk_edges(input int n);
        for (int k = 0; k < n; k++) fclk_edge();
    endtask

    function automatic int settle_of(input logic [3:0] c);
        case (c)
            4'b0000, 4'b0010:          return 512;
            4'b0001, 4'b1000, 4'b1010: return 256;
            4'b1001, 4'b1100, 4'b1110: return 128;
            4'b1101:                   return 64;
            default:                   return 0;
        endcase
    endfunction

    initial begin
        #1_900_000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R1: requests and clocks active during reset
        pm_cp = 1'b1; pm_adc = 1'b1; pm_dac = 1'b1;
        fclk_edges(4);
        check("R1 cp_en", cp_en, 0);
        check("R1 cp_ready", cp_ready, 0);
        check("R1 rate_err", rate_err, 0);
        check("R1 adc_run", adc_run, 0);
        check("R1 dac_run", dac_run, 0);
        pm_cp = 1'b0; pm_adc = 1'b0; pm_dac = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        // R2: released, no requests
        fclk_edges(5);
        check("R2 outputs idle", {cp_en, cp_ready, rate_err, adc_run, dac_run}, 0);

        // R3 R4 R5 R10: sweep every rate code
        for (int c = 0; c < 16; c++) begin
            int n;
            n = settle_of(4'(c));
            @(negedge clk) rate_code = 4'(c);
            @(negedge clk) pm_cp = 1'b1;
            repeat (2) @(negedge clk);
            check($sformatf("R3 cp_en code %0d", c), cp_en, 1);
            if (n != 0) begin
                fclk_edges(n - 1);
                check($sformatf("R4 early code %0d", c), cp_ready, 0);
                check($sformatf("R5 no err code %0d", c), rate_err, 0);
                fclk_edge();
                check($sformatf("R4 ready code %0d", c), cp_ready, 1);
            end else begin
                fclk_edges(520);
                check($sformatf("R5 no ready code %0d", c), cp_ready, 0);
                check($sformatf("R5 err code %0d", c), rate_err, 1);
            end
            @(negedge clk) pm_cp = 1'b0;
            @(negedge clk);
            check($sformatf("R10 cp clear code %0d", c), {cp_en, cp_ready}, 0);
        end

        // R7 R8: DAC needs presence only, ADC needs an edge
        fclk_edge();
        @(negedge clk) begin pm_adc = 1'b1; pm_dac = 1'b1; end
        repeat (2) @(negedge clk);
        check("R8 dac without edge", dac_run, 1);
        check("R7 adc waits edge", adc_run, 0);
        fclk_edge();
        check("R7 adc after edge", adc_run, 1);
        @(negedge clk) pm_adc = 1'b0;
        @(negedge clk);
        check("R10 adc clear", adc_run, 0);
        pm_adc = 1'b1;
        fclk_edge();
        check("R7 adc again", adc_run, 1);

        // R9: frame clock stops
        repeat (10) @(negedge clk);
        check("R9 still present", dac_run, 1);
        repeat (30) @(negedge clk);
        check("R9 dac absent", dac_run, 0);
        check("R9 adc absent", adc_run, 0);

        // R7: master clock absent blocks ADC
        mclk_on = 1'b0;
        repeat (50) @(negedge clk);
        pm_adc = 1'b0;
        @(negedge clk) pm_adc = 1'b1;
        fclk_edges(3);
        check("R7 adc no mclk", adc_run, 0);
        check("R8 dac no mclk", dac_run, 0);
        mclk_on = 1'b1;
        repeat (10) @(negedge clk);
        check("R8 dac mclk back", dac_run, 1);
        check("R7 adc before edge", adc_run, 0);
        fclk_edge();
        check("R7 adc mclk back", adc_run, 1);
        @(negedge clk) begin pm_adc = 1'b0; pm_dac = 1'b0; end
        @(negedge clk);
        check("R10 dac clear", dac_run, 0);

        // R6: count pauses while master clock absent
        rate_code = 4'b1101;
        @(negedge clk) pm_cp = 1'b1;
        repeat (2) @(negedge clk);
        fclk_edges(30);
        mclk_on = 1'b0;
        repeat (50) @(negedge clk);
        fclk_edges(10);
        mclk_on = 1'b1;
        repeat (10) @(negedge clk);
        fclk_edges(33);
        check("R6 paused edges ignored", cp_ready, 0);
        fclk_edge();
        check("R6 resumed count", cp_ready, 1);

        // R10: clearing pm_cp mid-count restarts
        @(negedge clk) pm_cp = 1'b0;
        repeat (2) @(negedge clk);
        pm_cp = 1'b1;
        repeat (2) @(negedge clk);
        fclk_edges(40);
        @(negedge clk) pm_cp = 1'b0;
        repeat (2) @(negedge clk);
        pm_cp = 1'b1;
        repeat (2) @(negedge clk);
        fclk_edges(63);
        check("R10 full restart early", cp_ready, 0);
        fclk_edge();
        check("R10 full restart ready", cp_ready, 1);

        // R11: rate change mid-count
        @(negedge clk) pm_cp = 1'b0;
        repeat (2) @(negedge clk);
        pm_cp = 1'b1;
        repeat (2) @(negedge clk);
        fclk_edges(40);
        @(negedge clk) rate_code = 4'b1001;
        repeat (2) @(negedge clk);
        fclk_edges(127);
        check("R11 new rate early", cp_ready, 0);
        fclk_edge();
        check("R11 new rate ready", cp_ready, 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule